// File: doc/BRIEF.md
# Packet Timestamp Capture Latch

This block snapshots a free-running system time counter when an event packet starts on the transmit or receive side. Each direction has a 64-bit stamp register and a valid flag. A stamp is taken only if the direction is enabled and its latch is free. After the capture the latch holds its value. It ignores every later packet until software reads the high stamp word, and that read releases the latch.

On transmit, the packet-start strobe comes with a mark bit from the queue. Only a marked packet is stamped, and the lock allows one marked packet to be outstanding at a time. On receive, an upstream parser supplies the header fields it has already decoded. A filter then picks the packets to stamp, using one of two modes:
- Version-1 messages over UDP, matched on one programmable message code.
- Every version-2 event message, carried either over UDP or as a raw Ethernet frame with the timing EtherType. The raw Ethernet case needs its own enable.

Software reaches everything through a small word-wide register port. Reads are combinational, and a read strobe carries the release side effect.

Top module: `pkt_stamp_latch`

## Requirements
- R1: After reset every register reads zero: both control words (valid bit 0, enable bit 4, receive mode bits 2:1), all four stamp words, the match word and the EtherType enable.
- R2: Transmit capture needs three conditions at the same rising edge: tx_sop_i high, tx_mark_i high, transmit enable set (address 0 bit 4) with valid clear. That edge loads time_i into the transmit stamp and sets valid (address 0 bit 0). The low word reads at address 1 and the high word at address 2.
- R3: While a direction's valid is set, qualifying packets leave the held stamp unchanged.
- R4: A read strobe on the high stamp word (address 2 transmit, address 5 receive) clears that direction's valid. A read of the low word (address 1 or 4) does not clear it.
- R5: A direction with its enable clear never captures. A transmit strobe without the mark never captures.
- R6: In receive mode 1 (version-2 events), a packet with version 2 is stamped if its message code is 0 to 3. This covers sync, delay request and both peer-delay messages. Codes 4 and above are not stamped.
- R7: In receive mode 0 (version-1 over layer 4), a packet is stamped only if three things hold: its version is 1, it is UDP with destination port equal to match word bits 31:16, and its message code equals match word bits 7:0.
- R8: In mode 1, a non-UDP frame is stamped only if two things hold: its EtherType is 0x88F7, and the EtherType enable (address 7 bit 0) is set.
- R9: In mode 1, a UDP packet is stamped only if its destination port equals match word bits 31:16. A packet whose version does not match the mode is not stamped.
- R10: A write to receive control (address 3) with bit 4 clear clears the mode field as well, whatever mode bits the write carries.
- R11: The match word (address 6) and the EtherType enable (address 7) read back the value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| time_i | input | 64 | System time counter |
| tx_sop_i | input | 1 | Transmit packet-start strobe |
| tx_mark_i | input | 1 | Transmit packet requests a stamp |
| rx_sop_i | input | 1 | Receive packet-start strobe |
| rx_etype_i | input | 16 | Parsed EtherType |
| rx_udp_i | input | 1 | Packet is UDP |
| rx_dport_i | input | 16 | Parsed UDP destination port |
| rx_ver_i | input | 4 | Parsed timing protocol version |
| rx_code_i | input | 8 | Parsed message code |
| reg_we_i | input | 1 | Register write strobe |
| reg_re_i | input | 1 | Register read strobe (side effects) |
| reg_addr_i | input | 3 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational on address |

## Verification
The assertions assume three things about the inputs:
- The parsed header fields are valid in the same cycle as rx_sop_i.
- A single cycle never carries both a write and a read strobe to the same word.
- time_i is stable around the sampling edge.

The stimulus meets all three. It changes every input only on the falling clock edge. It holds each strobe for exactly one cycle, and it presents the header fields together with the strobe. It issues register writes and register reads in separate cycles.

// File: rtl/pkt_stamp_pkg.sv
`timescale 1ns/1ps
package pkt_stamp_pkg;
  localparam int unsigned REG_W  = 32;
  localparam int unsigned ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADDR_TX_CTL = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_TX_LO  = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_TX_HI  = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_RX_CTL = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_RX_LO  = 3'd4;
  localparam logic [ADDR_W-1:0] ADDR_RX_HI  = 3'd5;
  localparam logic [ADDR_W-1:0] ADDR_MATCH  = 3'd6;
  localparam logic [ADDR_W-1:0] ADDR_ETYPE  = 3'd7;

  localparam int unsigned BIT_VALID = 0;
  localparam int unsigned BIT_EN    = 4;
  localparam int unsigned MODE_LSB  = 1;

  localparam logic [1:0] MODE_V1_L4  = 2'd0;
  localparam logic [1:0] MODE_V2_EVT = 2'd1;

  localparam logic [15:0] TIMING_ETYPE   = 16'h88F7;
  localparam int unsigned V2_EVENT_CODES = 4;
endpackage

// File: rtl/stamp_slot.sv
`timescale 1ns/1ps
module stamp_slot #(
  parameter int unsigned TIME_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              hit_i,
  input  logic              release_i,
  input  logic [TIME_W-1:0] time_i,
  output logic              valid_o,
  output logic [TIME_W-1:0] stamp_o
);
  logic cap;
  assign cap = en_i & hit_i & ~valid_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      stamp_o <= '0;
    end else if (cap) begin
      valid_o <= 1'b1;
      stamp_o <= time_i;
    end else if (release_i) begin
      valid_o <= 1'b0;
    end
  end

  a_r2_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && hit_i && !valid_o) |=> (valid_o && stamp_o == $past(time_i)));
  a_r3_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> $stable(stamp_o));
  a_r4_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && release_i) |=> !valid_o);
  a_r5_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !valid_o) |=> (!valid_o && $stable(stamp_o)));
endmodule

// File: rtl/rx_qualify.sv
`timescale 1ns/1ps
module rx_qualify
  import pkt_stamp_pkg::*;
#(
  parameter int unsigned CODE_W = 8,
  parameter int unsigned VER_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        mode_i,
  input  logic              etype_en_i,
  input  logic [REG_W-1:0]  match_i,
  input  logic              sop_i,
  input  logic [15:0]       etype_i,
  input  logic              udp_i,
  input  logic [15:0]       dport_i,
  input  logic [VER_W-1:0]  ver_i,
  input  logic [CODE_W-1:0] code_i,
  output logic              hit_o
);
  logic port_ok, l2_ok, v1_ok, v2_ok, sel_ok;

  assign port_ok = udp_i && (dport_i == match_i[REG_W-1:REG_W-16]);
  assign l2_ok   = !udp_i && etype_en_i && (etype_i == TIMING_ETYPE);
  assign v1_ok   = (ver_i == VER_W'(1)) && port_ok && (code_i == match_i[CODE_W-1:0]);
  assign v2_ok   = (ver_i == VER_W'(2)) && (code_i < CODE_W'(V2_EVENT_CODES)) && (port_ok || l2_ok);

  always_comb begin
    case (mode_i)
      MODE_V1_L4:  sel_ok = v1_ok;
      MODE_V2_EVT: sel_ok = v2_ok;
      default:     sel_ok = 1'b0;
    endcase
  end

  assign hit_o = sop_i && sel_ok;

  a_r8_l2_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && !udp_i) |-> (etype_en_i && etype_i == TIMING_ETYPE && mode_i == MODE_V2_EVT));
  a_r7_v1_udp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && mode_i == MODE_V1_L4) |-> (udp_i && ver_i == VER_W'(1)));
endmodule

// File: rtl/pkt_stamp_latch.sv
`timescale 1ns/1ps
module pkt_stamp_latch
  import pkt_stamp_pkg::*;
#(
  parameter int unsigned TIME_W = 64,
  parameter int unsigned CODE_W = 8,
  parameter int unsigned VER_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [TIME_W-1:0] time_i,
  input  logic              tx_sop_i,
  input  logic              tx_mark_i,
  input  logic              rx_sop_i,
  input  logic [15:0]       rx_etype_i,
  input  logic              rx_udp_i,
  input  logic [15:0]       rx_dport_i,
  input  logic [VER_W-1:0]  rx_ver_i,
  input  logic [CODE_W-1:0] rx_code_i,
  input  logic              reg_we_i,
  input  logic              reg_re_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o
);
  localparam int unsigned N_DIR  = 2;
  localparam int unsigned HALF_W = TIME_W / 2;
  localparam int unsigned DIR_TX = 0;
  localparam int unsigned DIR_RX = 1;

  logic             tx_en_q, rx_en_q, etype_en_q;
  logic [1:0]       rx_mode_q;
  logic [REG_W-1:0] match_q;
  logic             rx_hit;

  logic [N_DIR-1:0]  slot_en, slot_hit, slot_rel, slot_valid;
  logic [TIME_W-1:0] slot_stamp [N_DIR];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_en_q    <= 1'b0;
      rx_en_q    <= 1'b0;
      rx_mode_q  <= '0;
      match_q    <= '0;
      etype_en_q <= 1'b0;
    end else if (reg_we_i) begin
      case (reg_addr_i)
        ADDR_TX_CTL: tx_en_q <= reg_wdata_i[BIT_EN];
        ADDR_RX_CTL: begin
          rx_en_q   <= reg_wdata_i[BIT_EN];
          rx_mode_q <= reg_wdata_i[BIT_EN] ? reg_wdata_i[MODE_LSB+:2] : 2'b00;
        end
        ADDR_MATCH:  match_q    <= reg_wdata_i;
        ADDR_ETYPE:  etype_en_q <= reg_wdata_i[0];
        default: ;
      endcase
    end
  end

  rx_qualify #(.CODE_W(CODE_W), .VER_W(VER_W)) u_rx_qualify (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_i     (rx_mode_q),
    .etype_en_i (etype_en_q),
    .match_i    (match_q),
    .sop_i      (rx_sop_i),
    .etype_i    (rx_etype_i),
    .udp_i      (rx_udp_i),
    .dport_i    (rx_dport_i),
    .ver_i      (rx_ver_i),
    .code_i     (rx_code_i),
    .hit_o      (rx_hit)
  );

  assign slot_en[DIR_TX]  = tx_en_q;
  assign slot_en[DIR_RX]  = rx_en_q;
  assign slot_hit[DIR_TX] = tx_sop_i & tx_mark_i;
  assign slot_hit[DIR_RX] = rx_hit;
  assign slot_rel[DIR_TX] = reg_re_i && (reg_addr_i == ADDR_TX_HI);
  assign slot_rel[DIR_RX] = reg_re_i && (reg_addr_i == ADDR_RX_HI);

  for (genvar d = 0; d < N_DIR; d++) begin : g_dir
    stamp_slot #(.TIME_W(TIME_W)) u_slot (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .en_i      (slot_en[d]),
      .hit_i     (slot_hit[d]),
      .release_i (slot_rel[d]),
      .time_i    (time_i),
      .valid_o   (slot_valid[d]),
      .stamp_o   (slot_stamp[d])
    );
  end

  always_comb begin
    reg_rdata_o = '0;
    case (reg_addr_i)
      ADDR_TX_CTL: begin
        reg_rdata_o[BIT_VALID] = slot_valid[DIR_TX];
        reg_rdata_o[BIT_EN]    = tx_en_q;
      end
      ADDR_TX_LO: reg_rdata_o = REG_W'(slot_stamp[DIR_TX][HALF_W-1:0]);
      ADDR_TX_HI: reg_rdata_o = REG_W'(slot_stamp[DIR_TX][TIME_W-1:HALF_W]);
      ADDR_RX_CTL: begin
        reg_rdata_o[BIT_VALID]     = slot_valid[DIR_RX];
        reg_rdata_o[BIT_EN]        = rx_en_q;
        reg_rdata_o[MODE_LSB+:2]   = rx_mode_q;
      end
      ADDR_RX_LO: reg_rdata_o = REG_W'(slot_stamp[DIR_RX][HALF_W-1:0]);
      ADDR_RX_HI: reg_rdata_o = REG_W'(slot_stamp[DIR_RX][TIME_W-1:HALF_W]);
      ADDR_MATCH: reg_rdata_o = match_q;
      default:    reg_rdata_o[0] = etype_en_q;
    endcase
  end

  a_r10_mode_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == ADDR_RX_CTL && !reg_wdata_i[BIT_EN]) |=> (rx_mode_q == 2'b00 && !rx_en_q));
  a_r5_unmarked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(tx_sop_i && tx_mark_i) && !slot_valid[DIR_TX]) |=> !slot_valid[DIR_TX]);
endmodule

// File: tb/pkt_stamp_latch_test.sv
`timescale 1ns/1ps
module pkt_stamp_latch_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [63:0] time_i = '0;
  logic        tx_sop = 1'b0, tx_mark = 1'b0, rx_sop = 1'b0;
  logic [15:0] rx_etype = '0, rx_dport = '0;
  logic        rx_udp = 1'b0;
  logic [3:0]  rx_ver = '0;
  logic [7:0]  rx_code = '0;
  logic        we = 1'b0, re = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pkt_stamp_latch uut (
    .clk_i(clk), .rst_ni(rst_ni), .time_i(time_i),
    .tx_sop_i(tx_sop), .tx_mark_i(tx_mark), .rx_sop_i(rx_sop),
    .rx_etype_i(rx_etype), .rx_udp_i(rx_udp), .rx_dport_i(rx_dport),
    .rx_ver_i(rx_ver), .rx_code_i(rx_code),
    .reg_we_i(we), .reg_re_i(re), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata)
  );

  typedef struct packed {
    logic [1:0]  mode;
    logic        een;
    logic [15:0] etype;
    logic        udp;
    logic [15:0] port;
    logic [3:0]  ver;
    logic [7:0]  code;
    logic        exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{2'd1, 1'b0, 16'h0800, 1'b1, 16'd319, 4'd2, 8'd0, 1'b1, 4'd6},  // R6 sync
    '{2'd1, 1'b0, 16'h0800, 1'b1, 16'd319, 4'd2, 8'd1, 1'b1, 4'd6},  // R6 delay req
    '{2'd1, 1'b0, 16'h0800, 1'b1, 16'd319, 4'd2, 8'd2, 1'b1, 4'd6},  // R6 peer req
    '{2'd1, 1'b0, 16'h0800, 1'b1, 16'd319, 4'd2, 8'd3, 1'b1, 4'd6},  // R6 peer resp
    '{2'd1, 1'b0, 16'h0800, 1'b1, 16'd319, 4'd2, 8'd8, 1'b0, 4'd6},  // R6 general msg
    '{2'd1, 1'b0, 16'h0800, 1'b1, 16'd320, 4'd2, 8'd0, 1'b0, 4'd9},  // R9 port
    '{2'd1, 1'b1, 16'h88F7, 1'b0, 16'd0,   4'd2, 8'd0, 1'b1, 4'd8},  // R8 L2 on
    '{2'd1, 1'b0, 16'h88F7, 1'b0, 16'd0,   4'd2, 8'd0, 1'b0, 4'd8},  // R8 L2 off
    '{2'd1, 1'b1, 16'h0800, 1'b0, 16'd0,   4'd2, 8'd0, 1'b0, 4'd8},  // R8 other type
    '{2'd0, 1'b0, 16'h0800, 1'b1, 16'd319, 4'd1, 8'd1, 1'b1, 4'd7},  // R7 match
    '{2'd0, 1'b0, 16'h0800, 1'b1, 16'd319, 4'd1, 8'd0, 1'b0, 4'd7},  // R7 code
    '{2'd0, 1'b0, 16'h0800, 1'b1, 16'd320, 4'd1, 8'd1, 1'b0, 4'd7},  // R7 port
    '{2'd0, 1'b1, 16'h88F7, 1'b0, 16'd0,   4'd1, 8'd1, 1'b0, 4'd7},  // R7 no UDP
    '{2'd1, 1'b0, 16'h0800, 1'b1, 16'd319, 4'd1, 8'd0, 1'b0, 4'd9}   // R9 version
  };

  function automatic string tag(input logic [3:0] r);
    case (r)
      4'd6:    return "R6";
      4'd7:    return "R7";
      4'd8:    return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); re = 1'b1; addr = a;
    #1 d = rdata;
    @(negedge clk); re = 1'b0;
  endtask

  task automatic tx_pkt(input logic mark, input logic [63:0] t);
    @(negedge clk); tx_sop = 1'b1; tx_mark = mark; time_i = t;
    @(negedge clk); tx_sop = 1'b0; tx_mark = 1'b0; time_i = t + 64'd77;
  endtask

  task automatic rx_pkt(input vec_t v, input logic [63:0] t);
    @(negedge clk);
    rx_sop = 1'b1; rx_etype = v.etype; rx_udp = v.udp; rx_dport = v.port;
    rx_ver = v.ver; rx_code = v.code; time_i = t;
    @(negedge clk); rx_sop = 1'b0; time_i = t + 64'd77;
  endtask

  initial begin
    #800000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1 reset values
    rd(3'd0, d); chk("R1 tx ctl", 64'(d), 64'h0);
    rd(3'd3, d); chk("R1 rx ctl", 64'(d), 64'h0);
    rd(3'd1, d); chk("R1 tx lo", 64'(d), 64'h0);
    rd(3'd5, d); chk("R1 rx hi", 64'(d), 64'h0);
    rd(3'd6, d); chk("R1 match", 64'(d), 64'h0);
    rd(3'd7, d); chk("R1 etype", 64'(d), 64'h0);

    // R11 readback
    wr(3'd6, {16'd319, 16'h0001});
    rd(3'd6, d); chk("R11 match", 64'(d), 64'h013F_0001);
    wr(3'd7, 32'h1);
    rd(3'd7, d); chk("R11 etype", 64'(d), 64'h1);

    // R5 disabled and unmarked
    tx_pkt(1'b1, 64'hAAAA_0000_BBBB_0000);
    rd(3'd0, d); chk("R5 tx disabled", 64'(d), 64'h0);
    wr(3'd0, 32'h10);
    tx_pkt(1'b0, 64'hAAAA_0000_BBBB_0001);
    rd(3'd0, d); chk("R5 unmarked", 64'(d), 64'h10);

    // R2 capture
    tx_pkt(1'b1, 64'h1122_3344_5566_7788);
    rd(3'd0, d); chk("R2 tx valid", 64'(d), 64'h11);
    rd(3'd1, d); chk("R2 tx lo", 64'(d), 64'h5566_7788);
    rd(3'd0, d); chk("R4 lo read keeps valid", 64'(d), 64'h11);
    // R3 locked
    tx_pkt(1'b1, 64'h9999_8888_7777_6666);
    rd(3'd1, d); chk("R3 lo held", 64'(d), 64'h5566_7788);
    rd(3'd2, d); chk("R2 tx hi", 64'(d), 64'h1122_3344);
    rd(3'd0, d); chk("R4 hi read clears", 64'(d), 64'h10);
    tx_pkt(1'b1, 64'h0000_0005_0000_0006);
    rd(3'd1, d); chk("R4 recapture lo", 64'(d), 64'h6);
    rd(3'd2, d); chk("R4 recapture hi", 64'(d), 64'h5);

    // R10 mode clear on disable
    wr(3'd3, 32'h12);
    rd(3'd3, d); chk("R10 enabled mode", 64'(d), 64'h12);
    wr(3'd3, 32'h02);
    rd(3'd3, d); chk("R10 disabled mode", 64'(d), 64'h0);

    // R5 rx disabled
    rx_pkt(VECS[0], 64'h1);
    rd(3'd3, d); chk("R5 rx disabled", 64'(d), 64'h0);

    // receive filter table
    for (int i = 0; i < NV; i++) begin
      logic [63:0] t;
      t = 64'h0000_00AB_0000_1000 + 64'(i);
      wr(3'd3, 32'h10 | (32'(VECS[i].mode) << 1));
      wr(3'd7, 32'(VECS[i].een));
      rx_pkt(VECS[i], t);
      rd(3'd3, d);
      chk(tag(VECS[i].req), 64'(d[0]), 64'(VECS[i].exp));
      if (VECS[i].exp) begin
        rd(3'd4, d); chk(tag(VECS[i].req), 64'(d), {32'h0, t[31:0]});
      end
      rd(3'd5, d);
      if (VECS[i].exp) chk(tag(VECS[i].req), 64'(d), {32'h0, t[63:32]});
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule